// File: doc/BRIEF.md
# Repeated-Value Sequence Counter

This block is a free-running synchronous counter. Its 2-bit output steps through the five-value pattern 00, 01, 00, 10, 11 and then starts again. The value 00 appears twice in each pass, so the output cannot also be the state. The counter therefore keeps a 3-bit state register in which every step has its own code, and the output is decoded from that state.

The next-state logic can be built three ways, and a parameter picks one. The first writes the next state straight into plain data registers. The second computes toggle enables and applies each one to its stage. The third computes set/clear (J/K) excitation pairs and applies them to their stages. All three implement the same transition function, including how the three unused codes are steered back onto the cycle. The unused codes are 010, 101 and 111. A flag marks when the register holds one of them.

Top module: `rvc_seq_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state after that edge is 000, `count_o` is 00 and `illegal_o` is 0.
- R2: With `rst` low, the state advances one step per rising edge through the loop 000 -> 001 -> 100 -> 110 -> 011 -> 000. State bits are ordered {Q2,Q1,Q0} with Q2 the MSB of `state_o`.
- R3: `count_o` always equals `state_o[1:0]`, so across the loop it reads 00, 01, 00, 10, 11. It changes value on every clock while out of reset.
- R4: `illegal_o` is 1 exactly when `state_o` is 010, 101 or 111, and it follows the state without a clock delay.
- R5: From 010, one clock with `rst` low leads to 001.
- R6: From 101, one clock with `rst` low leads to 110.
- R7: From 111, the counter passes through 010 and reaches 001 two clocks later. No unused code needs more than two clocks to rejoin the loop.
- R8: For the same reset and clock history, the data-register style (`STYLE`=STYLE_D), the toggle style (STYLE_T) and the set/clear style (STYLE_JK) hold identical state in every cycle. This includes recovery from the unused codes.
- R9: Reset takes priority over recovery. From an unused code with `rst` high, the next state is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| count_o | output | 2 | Counter value decoded from the state |
| state_o | output | 3 | Raw state register {Q2,Q1,Q0} |
| illegal_o | output | 1 | High while the state is an unused code |

## Verification
The bound checker tests, on every clock, each of the five loop transitions and the one-step exits from 010, 101 and 111. It also checks that the visible count never holds still out of reset. Agreement between the three register styles cannot be seen inside a single instance. The bench runs all three side by side and compares them each cycle, and it also covers reset values and the combinational illegal flag. Unused codes are reached only by overriding the register, so the recovery paths and reset priority are shown by the bench's forced-state scenarios.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

    localparam int STATE_W = 3;
    localparam int COUNT_W = 2;

    typedef enum logic [1:0] {
        STYLE_D  = 2'd0,
        STYLE_T  = 2'd1,
        STYLE_JK = 2'd2
    } reg_style_e;

    localparam logic [STATE_W-1:0] ST_A = 3'b000;
    localparam logic [STATE_W-1:0] ST_B = 3'b001;
    localparam logic [STATE_W-1:0] ST_C = 3'b100;
    localparam logic [STATE_W-1:0] ST_D = 3'b110;
    localparam logic [STATE_W-1:0] ST_E = 3'b011;

    localparam logic [STATE_W-1:0] ST_X0 = 3'b010;
    localparam logic [STATE_W-1:0] ST_X1 = 3'b101;
    localparam logic [STATE_W-1:0] ST_X2 = 3'b111;

    typedef struct packed {
        logic [STATE_W-1:0] set_j;
        logic [STATE_W-1:0] clr_k;
    } jk_drive_t;

endpackage

// File: rtl/rvc_next_d.sv
module rvc_next_d
    import rvc_pkg::*;
(
    input  logic [STATE_W-1:0] state_i,
    output logic [STATE_W-1:0] next_o
);
    logic q2, q1, q0;

    always_comb begin
        q2 = state_i[2];
        q1 = state_i[1];
        q0 = state_i[0];
        next_o[2] = (q2 & ~q1) | (~q1 & q0);
        next_o[1] = q2;
        next_o[0] = (~q2 & ~q0) | (q1 & ~q0);
    end
endmodule

// File: rtl/rvc_next_t.sv
module rvc_next_t
    import rvc_pkg::*;
(
    input  logic [STATE_W-1:0] state_i,
    output logic [STATE_W-1:0] next_o
);
    logic [STATE_W-1:0] tog;

    // Toggle enables: a stage flips when its next value differs from now.
    always_comb begin
        tog[2] = (~state_i[2] & ~state_i[1] & state_i[0]) | (state_i[2] & state_i[1]);
        tog[1] = state_i[2] ^ state_i[1];
        tog[0] = state_i[0] | ~state_i[2] | state_i[1];
    end

    // One toggle stage per bit.
    for (genvar gi = 0; gi < STATE_W; gi++) begin : g_stage
        assign next_o[gi] = tog[gi] ? ~state_i[gi] : state_i[gi];
    end
endmodule

// File: rtl/rvc_next_jk.sv
module rvc_next_jk
    import rvc_pkg::*;
(
    input  logic [STATE_W-1:0] state_i,
    output logic [STATE_W-1:0] next_o
);
    jk_drive_t drv;

    // Set inputs matter only while a stage is 0, clear inputs only while it is 1.
    always_comb begin
        drv.set_j[2] = ~state_i[1] & state_i[0];
        drv.clr_k[2] = state_i[1];
        drv.set_j[1] = state_i[2];
        drv.clr_k[1] = ~state_i[2];
        drv.set_j[0] = ~state_i[2] | state_i[1];
        drv.clr_k[0] = 1'b1;
    end

    // One set/clear stage per bit: 00 hold, 10 set, 01 clear, 11 flip.
    for (genvar gi = 0; gi < STATE_W; gi++) begin : g_stage
        assign next_o[gi] = (drv.set_j[gi] & ~state_i[gi]) | (~drv.clr_k[gi] & state_i[gi]);
    end
endmodule

// File: rtl/rvc_seq_counter.sv
module rvc_seq_counter
    import rvc_pkg::*;
#(
    parameter reg_style_e STYLE = STYLE_D
) (
    input  logic               clk,
    input  logic               rst,
    output logic [COUNT_W-1:0] count_o,
    output logic [STATE_W-1:0] state_o,
    output logic               illegal_o
);
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;
    logic [STATE_W-1:0] step_nxt;

    if (STYLE == STYLE_T) begin : g_tog
        rvc_next_t u_nx (.state_i(state_q), .next_o(step_nxt));
    end else if (STYLE == STYLE_JK) begin : g_jk
        rvc_next_jk u_nx (.state_i(state_q), .next_o(step_nxt));
    end else begin : g_dat
        rvc_next_d u_nx (.state_i(state_q), .next_o(step_nxt));
    end

    always_comb begin
        state_d = rst ? ST_A : step_nxt;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign state_o   = state_q;
    assign count_o   = state_q[COUNT_W-1:0];
    assign illegal_o = (state_q == ST_X0) | (state_q == ST_X1) | (state_q == ST_X2);
endmodule

// File: rtl/rvc_seq_counter_chk.sv
module rvc_seq_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] count_o,
    input logic [2:0] state_o,
    input logic       illegal_o
);
    // R2
    step_a_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'b000) |=> (state_o == 3'b001));
    // R2
    step_b_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'b001) |=> (state_o == 3'b100));
    // R2
    step_c_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'b100) |=> (state_o == 3'b110));
    // R2
    step_d_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'b110) |=> (state_o == 3'b011));
    // R2
    step_e_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'b011) |=> (state_o == 3'b000));
    // R5
    exit_010_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'b010) |=> (state_o == 3'b001));
    // R6
    exit_101_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'b101) |=> (state_o == 3'b110));
    // R7
    exit_111_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'b111) |=> (state_o == 3'b010));
    // R7
    unused_leaves_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> (!illegal_o || state_o == 3'b010));
    // R3
    count_moves_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> !$stable(count_o));
endmodule

bind rvc_seq_counter rvc_seq_counter_chk u_chk (
    .clk(clk), .rst(rst), .count_o(count_o), .state_o(state_o), .illegal_o(illegal_o)
);

// File: tb/rvc_seq_counter_tb.sv
`timescale 1ns/1ps
module rvc_seq_counter_tb;
    import rvc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;
    logic [2:0] force_val = 3'b000;

    logic [1:0] cnt_d, cnt_t, cnt_j;
    logic [2:0] st_d, st_t, st_j;
    logic       il_d, il_t, il_j;

    always #2.5 clk = ~clk;

    rvc_seq_counter #(.STYLE(STYLE_D)) u_dut (
        .clk(clk), .rst(rst), .count_o(cnt_d), .state_o(st_d), .illegal_o(il_d));
    rvc_seq_counter #(.STYLE(STYLE_T)) u_dut_t (
        .clk(clk), .rst(rst), .count_o(cnt_t), .state_o(st_t), .illegal_o(il_t));
    rvc_seq_counter #(.STYLE(STYLE_JK)) u_dut_jk (
        .clk(clk), .rst(rst), .count_o(cnt_j), .state_o(st_j), .illegal_o(il_j));

    function automatic logic [2:0] loop_at(int i);
        case (i % 5)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b100;
            3: return 3'b110;
            default: return 3'b011;
        endcase
    endfunction

    function automatic bit is_unused(logic [2:0] s);
        return (s == 3'b010) || (s == 3'b101) || (s == 3'b111);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req, logic [2:0] exp_st);
        check(req, "state D",  st_d, exp_st);
        check(req, "state T",  st_t, exp_st);
        check(req, "state JK", st_j, exp_st);
        check("R3", "count", cnt_d, exp_st[1:0]);
        check("R3", "count T", cnt_t, exp_st[1:0]);
        check("R3", "count JK", cnt_j, exp_st[1:0]);
        check("R4", "illegal", il_d, is_unused(exp_st));
        check("R8", "T vs D", st_t, st_d);
        check("R8", "JK vs D", st_j, st_d);
    endtask

    task automatic force_all();
        force u_dut.state_q    = force_val;
        force u_dut_t.state_q  = force_val;
        force u_dut_jk.state_q = force_val;
    endtask

    task automatic release_all();
        release u_dut.state_q;
        release u_dut_t.state_q;
        release u_dut_jk.state_q;
    endtask

    // Park the counter on an unused code while rst is high, then let it run.
    task automatic recover(string req, logic [2:0] code, logic [2:0] exp1);
        @(negedge clk);
        rst = 1'b1;
        force_val = code;
        force_all();
        #1;
        check("R4", "illegal D forced",  il_d, 1);
        check("R4", "illegal T forced",  il_t, 1);
        check("R4", "illegal JK forced", il_j, 1);
        @(negedge clk);
        release_all();
        rst = 1'b0;
        @(negedge clk);
        check_all(req, exp1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check_all("R1", 3'b000);

        rst = 1'b0;
        for (int i = 1; i <= 15; i++) begin
            @(negedge clk);
            check_all("R2", loop_at(i));
        end

        recover("R5", 3'b010, 3'b001);
        for (int i = 2; i <= 6; i++) begin
            @(negedge clk);
            check_all("R2", loop_at(i));
        end

        recover("R6", 3'b101, 3'b110);
        @(negedge clk);
        check_all("R6", 3'b011);

        recover("R7", 3'b111, 3'b010);
        @(negedge clk);
        check_all("R7", 3'b001);
        @(negedge clk);
        check_all("R7", 3'b100);

        // R9: reset held through the cycle after an unused code
        @(negedge clk);
        rst = 1'b1;
        force_val = 3'b111;
        force_all();
        @(negedge clk);
        release_all();
        @(negedge clk);
        check_all("R9", 3'b000);
        rst = 1'b0;
        @(negedge clk);
        check_all("R9", 3'b001);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule